// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is one timer channel built around a 16-bit up-counter. A single-cycle reference tick drives a power-of-two prescaler. Each divided tick advances the counter by one. Two 16-bit compare values are checked against every counter step. A step that lands on a compare value latches a sticky event flag. The interrupt request is the OR of the latched flags whose events have been enabled.

Software reaches the channel over a small 16-bit register bus with a word address. Writes are single-cycle strobes and reads return data in the same cycle. A usual one-shot or periodic interval takes three writes:
- load the second compare value,
- write zero to the counter,
- write the setup word with count-enable set.

The counter folds back to zero on the divided tick after it equals the second compare value, so the period is that value plus one steps. The first write to the setup word claims the timer and freezes its divider and event-mode fields until the next reset.

Top module: `cmt_top`

## Requirements
- R1: After reset, all four registers read 0 and `irqOut` is 0.
- R2: Registers are selected by `busAddr`:
  - 0 selects compare value A.
  - 1 selects compare value B.
  - 2 selects the counter.
  - 3 selects the setup word.

  Compare values written read back unchanged.
- R3: While counting is enabled, the counter advances once every 2^s reference ticks, where s is setup bits 3:0. Values of s above 8 behave as 8, and the stored field still reads back as written.
- R4: The counter holds its value while count-enable (setup bit 15) is 0, and during cycles with `tickIn` low.
- R5: On a divided tick, a counter equal to compare value B goes to 0 instead of incrementing.
- R6: A counter step that lands on compare value A sets flag A (setup bit 13). A counter step that lands on compare value B sets flag B (setup bit 14). Both flags stay set until cleared.
- R7: A setup write with 1 in bit 13 or bit 14 clears the matching flag, and a 0 leaves that flag as it is. One write with bit 15 at 0 and both flag bits at 1 stops the counter and clears both flags.
- R8: After the first setup write, bit 12 reads 1 until reset. From then on, writes cannot change the divider field (bits 3:0) or the event-mode field (bits 9:8).
- R9: `irqOut` equals (flag A AND mode bit 8) OR (flag B AND mode bit 9). Mode value 3 therefore enables both events.
- R10: A counter write loads the written value, restarts the prescaler phase and never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Reference tick, one pulse per cycle when high |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | Write strobe, valid together with `busSel` |
| busAddr | input | 2 | Word address: 0 compare A, 1 compare B, 2 counter, 3 setup |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt request |

## Verification
Read data is combinational, so a register value can be sampled a fraction of a cycle after its address is applied. Counter steps and flag sets happen at the clock edge that carries the qualifying tick, and `irqOut` follows the flags with no further delay. Writes take effect at the edge that carries the strobe.

The bench drives ticks and writes at the falling edge and samples at the next falling edge. After T tick edges it therefore expects exactly floor(T/2^s) steps, folded modulo the compare-B value plus one. Random trials use a fresh reset each time, because the divider field freezes after the first setup write.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CNT_W     = 16;
  localparam int SCALE_W   = 4;
  localparam int MODE_W    = 2;
  localparam int MAX_SCALE = 8;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMPA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMPB  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SETUP = 2'd3;

  localparam int BIT_EN    = 15;
  localparam int BIT_FLAGB = 14;
  localparam int BIT_FLAGA = 13;
  localparam int BIT_LOCK  = 12;
  localparam int MODE_LSB  = 8;

  typedef struct packed {
    logic wrCmpA;
    logic wrCmpB;
    logic wrCount;
    logic divTick;
  } cmt_strobe_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
#(
  parameter int SW   = SCALE_W,
  parameter int MAXS = MAX_SCALE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          restart,
  input  logic          tickIn,
  input  logic [SW-1:0] scale,
  output logic          divTick
);
  logic [MAXS-1:0] phase;
  logic [MAXS-1:0] mask;
  logic [SW-1:0]   effScale;

  assign effScale = (int'(scale) > MAXS) ? SW'(MAXS) : scale;

  always_comb begin
    for (int i = 0; i < MAXS; i++) mask[i] = (i < int'(effScale));
  end

  assign divTick = enable && tickIn && ((phase & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable || restart) phase <= '0;
    else if (tickIn)                  phase <= phase + 1'b1;
  end
endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
  import cmt_pkg::*;
#(
  parameter int DW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickIn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DW-1:0]     busWdata,
  input  logic              hitA,
  input  logic              hitB,
  output cmt_strobe_t       strobes,
  output logic              wrSetup,
  output logic              countEn,
  output logic              locked,
  output logic              flagA,
  output logic              flagB,
  output logic [SCALE_W-1:0] scale,
  output logic [MODE_W-1:0]  mode,
  output logic              irq
);
  logic wrStb;
  logic unusedWdata;
  logic divTick;

  assign unusedWdata = ^{busWdata[7:4], busWdata[11:10], busWdata[BIT_LOCK]};

  assign wrStb   = busSel && busWrite;
  assign wrSetup = wrStb && (busAddr == ADDR_SETUP);

  assign strobes.wrCmpA  = wrStb && (busAddr == ADDR_CMPA);
  assign strobes.wrCmpB  = wrStb && (busAddr == ADDR_CMPB);
  assign strobes.wrCount = wrStb && (busAddr == ADDR_COUNT);
  assign strobes.divTick = divTick;

  cmt_prescaler #(.SW(SCALE_W), .MAXS(MAX_SCALE)) presc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (countEn),
    .restart (strobes.wrCount),
    .tickIn  (tickIn),
    .scale   (scale),
    .divTick (divTick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countEn <= 1'b0;
      locked  <= 1'b0;
      scale   <= '0;
      mode    <= '0;
    end else if (wrSetup) begin
      countEn <= busWdata[BIT_EN];
      locked  <= 1'b1;
      if (!locked) begin
        scale <= busWdata[SCALE_W-1:0];
        mode  <= busWdata[MODE_LSB +: MODE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagA <= 1'b0;
      flagB <= 1'b0;
    end else begin
      flagA <= hitA || (flagA && !(wrSetup && busWdata[BIT_FLAGA]));
      flagB <= hitB || (flagB && !(wrSetup && busWdata[BIT_FLAGB]));
    end
  end

  assign irq = (flagA && mode[0]) || (flagB && mode[1]);
endmodule

// File: rtl/cmt_datapath.sv
module cmt_datapath
  import cmt_pkg::*;
#(
  parameter int DW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmt_strobe_t   strobes,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmpA,
  output logic [DW-1:0] cmpB,
  output logic [DW-1:0] count,
  output logic          hitA,
  output logic          hitB
);
  logic [DW-1:0] nextCount;
  logic          stepping;

  assign nextCount = (count == cmpB) ? '0 : count + 1'b1;
  assign stepping  = strobes.divTick && !strobes.wrCount;
  assign hitA      = stepping && (nextCount == cmpA);
  assign hitB      = stepping && (nextCount == cmpB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpA  <= '0;
      cmpB  <= '0;
      count <= '0;
    end else begin
      if (strobes.wrCmpA) cmpA <= wdata;
      if (strobes.wrCmpB) cmpB <= wdata;
      if (strobes.wrCount) count <= wdata;
      else if (stepping)   count <= nextCount;
    end
  end
endmodule

// File: rtl/cmt_top.sv
module cmt_top
  import cmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tickIn,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [1:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        irqOut
);
  cmt_strobe_t        strobes;
  logic               wrSetupStb;
  logic               countEn;
  logic               setupLocked;
  logic               flagAQ;
  logic               flagBQ;
  logic [SCALE_W-1:0] scaleQ;
  logic [MODE_W-1:0]  modeQ;
  logic [CNT_W-1:0]   cmpAQ;
  logic [CNT_W-1:0]   cmpBQ;
  logic [CNT_W-1:0]   countQ;
  logic               hitA;
  logic               hitB;
  logic [CNT_W-1:0]   setupWord;

  cmt_ctrl #(.DW(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickIn   (tickIn),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .hitA     (hitA),
    .hitB     (hitB),
    .strobes  (strobes),
    .wrSetup  (wrSetupStb),
    .countEn  (countEn),
    .locked   (setupLocked),
    .flagA    (flagAQ),
    .flagB    (flagBQ),
    .scale    (scaleQ),
    .mode     (modeQ),
    .irq      (irqOut)
  );

  cmt_datapath #(.DW(CNT_W)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .wdata   (busWdata),
    .cmpA    (cmpAQ),
    .cmpB    (cmpBQ),
    .count   (countQ),
    .hitA    (hitA),
    .hitB    (hitB)
  );

  always_comb begin
    setupWord                          = '0;
    setupWord[BIT_EN]                  = countEn;
    setupWord[BIT_FLAGB]               = flagBQ;
    setupWord[BIT_FLAGA]               = flagAQ;
    setupWord[BIT_LOCK]                = setupLocked;
    setupWord[MODE_LSB +: MODE_W]      = modeQ;
    setupWord[SCALE_W-1:0]             = scaleQ;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CMPA:  busRdata = cmpAQ;
      ADDR_CMPB:  busRdata = cmpBQ;
      ADDR_COUNT: busRdata = countQ;
      default:    busRdata = setupWord;
    endcase
  end
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tickIn,
  input logic [15:0] busWdata,
  input logic        wrSetupStb,
  input logic        wrCountStb,
  input logic        divTick,
  input logic        countEn,
  input logic        setupLocked,
  input logic [3:0]  scaleQ,
  input logic        flagAQ,
  input logic        flagBQ,
  input logic [15:0] countQ,
  input logic [15:0] cmpBQ,
  input logic        irqOut
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (countQ == 16'd0 && !irqOut && !setupLocked));

  a_r3_no_tick_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickIn || !countEn) |-> !divTick);

  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!countEn && !wrCountStb) |=> $stable(countQ));

  a_r5_wrap_at_b: assert property (@(posedge clk) disable iff (!rst_n)
    (divTick && !wrCountStb && countQ == cmpBQ) |=> countQ == 16'd0);

  a_r6_flagb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flagBQ && !(wrSetupStb && busWdata[14])) |=> flagBQ);

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    setupLocked |=> setupLocked);

  a_r8_scale_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    setupLocked |=> $stable(scaleQ));

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!flagAQ && !flagBQ) |-> !irqOut);
endmodule

bind cmt_top cmt_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tickIn      (tickIn),
  .busWdata    (busWdata),
  .wrSetupStb  (wrSetupStb),
  .wrCountStb  (strobes.wrCount),
  .divTick     (strobes.divTick),
  .countEn     (countEn),
  .setupLocked (setupLocked),
  .scaleQ      (scaleQ),
  .flagAQ      (flagAQ),
  .flagBQ      (flagBQ),
  .countQ      (countQ),
  .cmpBQ       (cmpBQ),
  .irqOut      (irqOut)
);

// File: tb/cmt_top_tb.sv
`timescale 1ns/1ps
module cmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickIn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  cmt_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickIn   (tickIn),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  function automatic int stepsFor(int ticks, int s);
    int se = (s > 8) ? 8 : s;
    return ticks >> se;
  endfunction

  function automatic int countFor(int steps, int cmpB);
    return steps % (cmpB + 1);
  endfunction

  function automatic bit flagFor(int steps, int cmpVal);
    return steps >= cmpVal;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; tickIn = 1'b0; busSel = 1'b0; busWrite = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic runTicks(int n);
    tickIn = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd20240917));

    // R1: reset state
    doReset();
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), rd);
      check("R1 register after reset", rd, 16'h0000);
    end
    check("R1 irq after reset", {15'd0, irqOut}, 16'h0000);

    // R2: readback, R4: counter holds before enable
    regWrite(2'd0, 16'h1234);
    regWrite(2'd1, 16'hABCD);
    regWrite(2'd2, 16'h0055);
    regRead(2'd0, rd); check("R2 compare A readback", rd, 16'h1234);
    regRead(2'd1, rd); check("R2 compare B readback", rd, 16'hABCD);
    runTicks(9);
    regRead(2'd2, rd); check("R4 counter held while disabled", rd, 16'h0055);

    // R8: lock freezes divider and mode
    regWrite(2'd3, 16'h0302);
    regRead(2'd3, rd); check("R8 first setup write", rd, 16'h1302);
    regWrite(2'd3, 16'h0105);
    regRead(2'd3, rd); check("R8 locked fields unchanged", rd, 16'h1302);

    // R6/R9/R5: directed run, scale 0, A=20, B=30, mode B only
    doReset();
    regWrite(2'd0, 16'd20);
    regWrite(2'd1, 16'd30);
    regWrite(2'd2, 16'd0);
    regWrite(2'd3, 16'h8200);
    runTicks(25);
    regRead(2'd2, rd); check("R3 count at scale 0", rd, 16'd25);
    regRead(2'd3, rd); check("R6 flag A set only", rd, 16'hB200);
    check("R9 irq masked for A", {15'd0, irqOut}, 16'h0000);
    runTicks(6);
    regRead(2'd2, rd); check("R5 wrap after B", rd, 16'd0);
    regRead(2'd3, rd); check("R6 both flags", rd, 16'hF200);
    check("R9 irq on flag B", {15'd0, irqOut}, 16'h0001);

    // R7: write-one-to-clear
    regWrite(2'd3, 16'hA000);
    regRead(2'd3, rd); check("R7 clear A only", rd, 16'hD200);
    check("R9 irq still set", {15'd0, irqOut}, 16'h0001);
    regWrite(2'd3, 16'h6000);
    regRead(2'd3, rd); check("R7 stop and clear both", rd, 16'h1200);
    check("R7 irq dropped", {15'd0, irqOut}, 16'h0000);
    regWrite(2'd2, 16'd7);
    runTicks(10);
    regRead(2'd2, rd); check("R4 held after stop", rd, 16'd7);

    // R10: counter write loads value, sets no flag
    regWrite(2'd3, 16'h8000);
    runTicks(5);
    regRead(2'd2, rd); check("R10 count from loaded value", rd, 16'd12);
    regWrite(2'd2, 16'd20);
    regRead(2'd3, rd); check("R10 no flag from write", rd, 16'h9200);
    regWrite(2'd2, 16'd30);
    regRead(2'd3, rd); check("R10 no flag B from write", rd, 16'h9200);
    check("R10 irq quiet", {15'd0, irqOut}, 16'h0000);

    // R3: scale above 8 behaves as 8
    doReset();
    regWrite(2'd1, 16'hFFFE);
    regWrite(2'd3, 16'h800C);
    runTicks(3 * 256 + 100);
    regRead(2'd2, rd); check("R3 scale 12 acts as 8", rd, 16'd3);
    regRead(2'd3, rd); check("R3 scale field readback", rd, 16'h900C);

    // R4: gaps in tickIn
    doReset();
    regWrite(2'd1, 16'd100);
    regWrite(2'd3, 16'h8001);
    for (int i = 0; i < 40; i++) begin
      tickIn = i[0];
      @(posedge clk);
      @(negedge clk);
    end
    tickIn = 1'b0;
    regRead(2'd2, rd); check("R4 ticks only when tickIn high", rd, 16'd10);

    // Random trials: R3 R5 R6 R9
    for (int t = 0; t < 16; t++) begin
      int s     = int'($urandom % 4);
      int cb    = 15 + int'($urandom % 30);
      int ca    = 1 + int'($urandom % cb);
      int ticks = 1 + int'($urandom % (((cb + 1) << s) * 2));
      int n;
      bit fa, fb;
      doReset();
      regWrite(2'd0, 16'(ca));
      regWrite(2'd1, 16'(cb));
      regWrite(2'd2, 16'd0);
      regWrite(2'd3, 16'(16'h8300 | s));
      runTicks(ticks);
      n  = stepsFor(ticks, s);
      fa = flagFor(n, ca);
      fb = flagFor(n, cb);
      regRead(2'd2, rd); check("R3 R5 random count", rd, 16'(countFor(n, cb)));
      regRead(2'd3, rd);
      check("R6 random flags", rd, 16'(16'h9300 | s | (fa << 13) | (fb << 14)));
      check("R9 random irq", {15'd0, irqOut}, {15'd0, fa | fb});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule